// File: doc/BRIEF.md
# Calendar Clock Register File with Alarm

This block is a 64-byte register file that keeps calendar time and raises alarm and update events. The lower bytes hold seconds, minutes, hours, day of week, day of month, month and a two-digit year, interleaved with alarm seconds, minutes and hours. These are followed by two control bytes, a flag byte and a validity byte. Every byte above that is plain storage. A one-cycle pulse on `tick_i`, expected once per second, opens an update window. While that window is open, the update-in-progress status is high. When the window closes, the whole carry chain from seconds to year is applied in a single clock edge.

Software reaches every byte through a multiplexed bus. A cycle with `as_i` high latches a byte index from `ad_i`. A later cycle with `ds_i` high then writes `ad_i` into that byte, when `we_i` is high, or reads it. Control byte B selects how the clock counts:
- binary or BCD counting
- 24-hour mode, or 12-hour mode with a PM flag
- a freeze bit that stops the clock so it can be loaded
- enables for the update-ended interrupt and the alarm interrupt

Top module: `cal_clock`

## Requirements
- R1: A cycle with `as_i`=1 latches `ad_i[5:0]` as the byte index. A later cycle with `ds_i`=1 and `we_i`=1 writes `ad_i` into that byte. A cycle with `ds_i`=1 and `we_i`=0 loads that byte onto `rd_o` at the next edge, and `rd_o` holds the value until the next read.
- R2: Bytes 14 to 63 and the alarm bytes 1, 3 and 5 read back exactly as written. Control byte B (index 11) reads back as written. Control byte A (index 10) reads back bits 6:0 as written.
- R3: The time bytes are: seconds (0), minutes (2), hours (4), day of week (6), day of month (7), month (8) and year (9). A tick starts a window of UIP_CYC cycles during which `uip_o` and byte 10 bit 7 read 1. At the edge that ends the window, the time advances by one second, with every carry applied in that same edge.
- R4: Byte 11 bit 2 selects the number format: 1 for binary, 0 for BCD. In BCD, seconds 0x09 step to 0x10 and 0x59 wrap to 0x00. In binary, 9 steps to 10 (0x0A).
- R5: Byte 11 bit 1 selects 24-hour mode (1, hours 0 to 23) or 12-hour mode (0). In 12-hour mode the hours run 1 to 12, with bit 7 set for PM. In 12-hour BCD mode, 11:59:59 AM (0x11) becomes 12 PM (0x92). Likewise, 11:59:59 PM (0x91) becomes 12 AM (0x12) and starts a new day.
- R6: Day of week counts 1 to 7 (1 = Sunday) and wraps 7 to 1. Months have 30 or 31 days, and February has 29 days when the year is a multiple of 4 and 28 otherwise. Month 12 wraps to 1. Year 99 wraps to 0.
- R7: While byte 11 bit 7 (freeze) is 1, ticks are ignored: no window opens, `uip_o` stays 0 and the time bytes keep their values.
- R8: At the edge that ends the window, the alarm is compared with the new time. It matches when each of the alarm seconds, minutes and hours bytes either equals the new time byte or has bits 7:6 both set, which means don't-care. On a match, `alm_o` pulses in the cycle before that edge, and the alarm flag (byte 12 bit 5) is set at that edge.
- R9: `upd_o` pulses in the cycle before that same edge, and the update flag (byte 12 bit 4) is set at that edge. Byte 12 bit 7 and `irq_o` equal (update flag AND byte 11 bit 4) OR (alarm flag AND byte 11 bit 5). Reading byte 12 returns the flags and clears them; a flag set in the same cycle as the read survives.
- R10: Byte 13 always reads 0x80. Writes to bytes 12 and 13 have no effect.
- R11: A bus write to a time byte in the cycle where the window ends takes precedence for that byte. The other time bytes still advance.
- R12: A tick that arrives while a window is already open is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second enable pulse |
| as_i | input | 1 | Address phase strobe |
| ds_i | input | 1 | Data phase strobe |
| we_i | input | 1 | Data phase direction, 1 = write |
| ad_i | input | 8 | Multiplexed byte index and write data |
| rd_o | output | 8 | Read data from the last read data phase |
| uip_o | output | 1 | Update window open |
| upd_o | output | 1 | Update commit pulse |
| alm_o | output | 1 | Alarm match pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
A bus write can land in the very cycle in which the update window commits the carry chain, so the two write paths into the time bytes meet on one edge. The bench latches the seconds index before a tick, waits until `upd_o` shows that the commit is pending, and drives the write in that cycle. It then expects the written seconds value together with an advanced minutes byte. A read of the flag byte can likewise coincide with a commit that sets a flag. The behavioural model, which is compared on every clock, checks that such a flag survives the clear.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef logic [7:0] byte_t;
  typedef byte_t [9:0] tbank_t;

  localparam int unsigned I_SEC  = 0;
  localparam int unsigned I_MIN  = 2;
  localparam int unsigned I_HR   = 4;
  localparam int unsigned I_DOW  = 6;
  localparam int unsigned I_DOM  = 7;
  localparam int unsigned I_MON  = 8;
  localparam int unsigned I_YR   = 9;
  localparam int unsigned I_CTLA = 10;
  localparam int unsigned I_CTLB = 11;
  localparam int unsigned I_FLG  = 12;
  localparam int unsigned I_VLD  = 13;
  localparam int unsigned I_RAM  = 14;

  localparam int unsigned B_H24 = 1;
  localparam int unsigned B_BIN = 2;
  localparam int unsigned B_UIE = 4;
  localparam int unsigned B_AIE = 5;
  localparam int unsigned B_SET = 7;

  localparam byte_t VLD_BYTE   = 8'h80;
  localparam byte_t CTLB_RESET = 8'h02;

  function automatic byte_t to_bin(byte_t v, logic bin);
    return bin ? v : (byte_t'(v[7:4]) * 8'd10) + byte_t'(v[3:0]);
  endfunction

  function automatic byte_t from_bin(byte_t n, logic bin);
    byte_t tens, ones;
    tens = n / 8'd10;
    ones = n % 8'd10;
    return bin ? n : {tens[3:0], ones[3:0]};
  endfunction

  function automatic byte_t month_days(byte_t mon, byte_t yr);
    case (mon)
      8'd2:                    return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                 return 8'd31;
    endcase
  endfunction

  // one-second step of the whole calendar, in the selected format
  function automatic tbank_t advance(tbank_t t, logic bin, logic h24);
    tbank_t nt;
    byte_t s, mi, hr, h12, dw, d, mo, yr, hb;
    nt  = t;
    s   = to_bin(t[I_SEC], bin) + 8'd1;
    mi  = to_bin(t[I_MIN], bin);
    d   = to_bin(t[I_DOM], bin);
    mo  = to_bin(t[I_MON], bin);
    yr  = to_bin(t[I_YR], bin);
    dw  = t[I_DOW];
    if (h24) hr = to_bin(t[I_HR], bin);
    else begin
      h12 = to_bin({1'b0, t[I_HR][6:0]}, bin);
      hr  = ((h12 == 8'd12) ? 8'd0 : h12) + (t[I_HR][7] ? 8'd12 : 8'd0);
    end
    if (s >= 8'd60) begin
      s  = 8'd0;
      mi = mi + 8'd1;
      if (mi >= 8'd60) begin
        mi = 8'd0;
        hr = hr + 8'd1;
        if (hr >= 8'd24) begin
          hr = 8'd0;
          dw = (dw >= 8'd7) ? 8'd1 : dw + 8'd1;
          d  = d + 8'd1;
          if (d > month_days(mo, yr)) begin
            d  = 8'd1;
            mo = mo + 8'd1;
            if (mo > 8'd12) begin
              mo = 8'd1;
              yr = (yr >= 8'd99) ? 8'd0 : yr + 8'd1;
            end
          end
        end
      end
    end
    nt[I_SEC] = from_bin(s, bin);
    nt[I_MIN] = from_bin(mi, bin);
    nt[I_DOW] = dw;
    nt[I_DOM] = from_bin(d, bin);
    nt[I_MON] = from_bin(mo, bin);
    nt[I_YR]  = from_bin(yr, bin);
    if (h24) nt[I_HR] = from_bin(hr, bin);
    else begin
      h12 = (hr == 8'd0) ? 8'd12 : ((hr > 8'd12) ? hr - 8'd12 : hr);
      hb  = from_bin(h12, bin);
      nt[I_HR] = {(hr >= 8'd12), hb[6:0]};
    end
    return nt;
  endfunction
endpackage

// File: rtl/cal_uip_timer.sv
module cal_uip_timer #(
  parameter int unsigned UIP_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hold_i,
  output logic uip_o,
  output logic commit_o
);
  localparam int unsigned CW = $clog2(UIP_CYC + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (tick_i && !hold_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(UIP_CYC - 1);
    end
  end

  assign uip_o    = busy_q;
  assign commit_o = busy_q && (cnt_q == '0) && !hold_i;

  AST_WINDOW_FROM_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uip_o) |-> $past(tick_i)); // R3
  AST_FROZEN_NO_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uip_o && hold_i) |=> !uip_o); // R7
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
  import cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       commit_i,
  input  logic       bin_i,
  input  logic       h24_i,
  input  logic       wr_i,
  input  logic [3:0] wr_idx_i,
  input  byte_t      wr_data_i,
  output tbank_t     time_o,
  output logic       alarm_o
);
  tbank_t     t_q, t_nx;
  logic [2:0] hit;

  assign t_nx = advance(t_q, bin_i, h24_i);

  // alarm byte 2k+1 guards time byte 2k; top bits 11 = don't care
  for (genvar k = 0; k < 3; k++) begin : g_alm
    assign hit[k] = (t_q[2*k+1][7:6] == 2'b11) || (t_q[2*k+1] == t_nx[2*k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q        <= '0;
      t_q[I_DOW] <= 8'd1;
      t_q[I_DOM] <= 8'd1;
      t_q[I_MON] <= 8'd1;
    end else begin
      for (int i = 0; i < 10; i++) begin
        if (wr_i && wr_idx_i == 4'(i)) t_q[i] <= wr_data_i;
        else if (commit_i)             t_q[i] <= t_nx[i];
      end
    end
  end

  assign time_o  = t_q;
  assign alarm_o = commit_i && (&hit);

  AST_SEC_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !(wr_i && wr_idx_i == 4'(I_SEC))) |=> (t_q[I_SEC] != $past(t_q[I_SEC]))); // R3
  AST_DOW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && t_q[I_DOW] >= 8'd1 && t_q[I_DOW] <= 8'd7 && !(wr_i && wr_idx_i == 4'(I_DOW)))
    |=> (t_q[I_DOW] >= 8'd1 && t_q[I_DOW] <= 8'd7)); // R6
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_idx_i < 4'd10) |=> (t_q[$past(wr_idx_i)] == $past(wr_data_i))); // R11
endmodule

// File: rtl/cal_scratch.sv
module cal_scratch #(
  parameter int unsigned BASE = 14,
  parameter int unsigned TOP  = 64,
  parameter int unsigned AW   = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] idx_i,
  input  logic [7:0]    wr_data_i,
  output logic [7:0]    rd_data_o
);
  localparam int unsigned DEPTH = TOP - BASE;
  localparam int unsigned IW    = $clog2(DEPTH);

  logic [7:0]    mem_q [DEPTH];
  logic [IW-1:0] off;
  logic          in_rng;

  assign in_rng = (idx_i >= AW'(BASE));
  assign off    = IW'(idx_i - AW'(BASE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (wr_i && in_rng) begin
      mem_q[off] <= wr_data_i;
    end
  end

  assign rd_data_o = in_rng ? mem_q[off] : '0;
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter int unsigned NBYTES  = 64,
  parameter int unsigned UIP_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       as_i,
  input  logic       ds_i,
  input  logic       we_i,
  input  logic [7:0] ad_i,
  output logic [7:0] rd_o,
  output logic       uip_o,
  output logic       upd_o,
  output logic       alm_o,
  output logic       irq_o
);
  localparam int unsigned AW = $clog2(NBYTES);

  logic [AW-1:0] idx_q;
  logic [6:0]    ctl_a_q;
  byte_t         ctl_b_q, rd_q, rd_mux, ram_rd, flg_byte;
  logic          uf_q, af_q, irqf;
  logic          wr, rd, time_wr, flg_rd;
  logic          uip_w, commit_w, alarm_w;
  tbank_t        time_w;

  assign wr      = ds_i && we_i;
  assign rd      = ds_i && !we_i;
  assign time_wr = wr && (idx_q < AW'(I_CTLA));
  assign flg_rd  = rd && (idx_q == AW'(I_FLG));

  cal_uip_timer #(.UIP_CYC(UIP_CYC)) u_timer (
    .clk_i, .rst_ni, .tick_i,
    .hold_i  (ctl_b_q[B_SET]),
    .uip_o   (uip_w),
    .commit_o(commit_w)
  );

  cal_time_core u_core (
    .clk_i, .rst_ni,
    .commit_i (commit_w),
    .bin_i    (ctl_b_q[B_BIN]),
    .h24_i    (ctl_b_q[B_H24]),
    .wr_i     (time_wr),
    .wr_idx_i (idx_q[3:0]),
    .wr_data_i(ad_i),
    .time_o   (time_w),
    .alarm_o  (alarm_w)
  );

  cal_scratch #(.BASE(I_RAM), .TOP(NBYTES), .AW(AW)) u_ram (
    .clk_i, .rst_ni,
    .wr_i     (wr),
    .idx_i    (idx_q),
    .wr_data_i(ad_i),
    .rd_data_o(ram_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      ctl_a_q <= '0;
      ctl_b_q <= CTLB_RESET;
      uf_q    <= 1'b0;
      af_q    <= 1'b0;
      rd_q    <= '0;
    end else begin
      if (as_i) idx_q <= ad_i[AW-1:0];
      if (wr && idx_q == AW'(I_CTLA)) ctl_a_q <= ad_i[6:0];
      if (wr && idx_q == AW'(I_CTLB)) ctl_b_q <= ad_i;
      if (rd) rd_q <= rd_mux;
      if (flg_rd) begin
        uf_q <= 1'b0;
        af_q <= 1'b0;
      end
      // a set in the read cycle overrides the clear
      if (commit_w) uf_q <= 1'b1;
      if (alarm_w)  af_q <= 1'b1;
    end
  end

  assign irqf     = (uf_q && ctl_b_q[B_UIE]) || (af_q && ctl_b_q[B_AIE]);
  assign flg_byte = {irqf, 1'b0, af_q, uf_q, 4'b0000};

  always_comb begin
    if (idx_q < AW'(I_CTLA))        rd_mux = time_w[idx_q[3:0]];
    else if (idx_q == AW'(I_CTLA))  rd_mux = {uip_w, ctl_a_q};
    else if (idx_q == AW'(I_CTLB))  rd_mux = ctl_b_q;
    else if (idx_q == AW'(I_FLG))   rd_mux = flg_byte;
    else if (idx_q == AW'(I_VLD))   rd_mux = VLD_BYTE;
    else                            rd_mux = ram_rd;
  end

  assign rd_o  = rd_q;
  assign uip_o = uip_w;
  assign upd_o = commit_w;
  assign alm_o = alarm_w;
  assign irq_o = irqf;

  AST_VLD_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && idx_q == AW'(I_VLD)) |=> (rd_o == VLD_BYTE)); // R10
  AST_UIP_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && idx_q == AW'(I_CTLA)) |=> (rd_o[7] == $past(uip_o))); // R3
  AST_SET_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_b_q[B_SET] && !(time_wr && idx_q == AW'(I_SEC))) |=> $stable(time_w[I_SEC])); // R7
  AST_ALARM_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm_o |=> af_q); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flg_rd && !upd_o && !alm_o) |=> (!uf_q && !af_q)); // R9
endmodule

// File: tb/cal_clock_test.sv
`timescale 1ns/1ps
module cal_clock_test;
  localparam int UIP = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tick = 1'b0, as_s = 1'b0, ds = 1'b0, we = 1'b0;
  logic [7:0] ad = 8'h00;
  logic [7:0] rd_o;
  logic       uip, upd, alm, irq;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  cal_clock #(.NBYTES(64), .UIP_CYC(UIP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .as_i(as_s), .ds_i(ds),
    .we_i(we), .ad_i(ad), .rd_o(rd_o), .uip_o(uip), .upd_o(upd),
    .alm_o(alm), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int m[64];
  int nx[10];
  int m_idx, m_cnt, m_rd;
  bit m_busy, m_uf, m_af;

  function automatic int dec(int v, bit bin);
    return bin ? v : ((v >> 4) * 10 + (v & 15));
  endfunction
  function automatic int enc(int n, bit bin);
    return bin ? n : (((n / 10) << 4) | (n % 10));
  endfunction
  function automatic int dim(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic void compute_next();
    bit bin = m[11][2];
    bit h24 = m[11][1];
    int s, mi, h, h12, d, mo, y;
    s = dec(m[0], bin); mi = dec(m[2], bin);
    d = dec(m[7], bin); mo = dec(m[8], bin); y = dec(m[9], bin);
    if (h24) h = dec(m[4], bin);
    else h = (dec(m[4] & 127, bin) % 12) + ((m[4] & 128) ? 12 : 0);
    for (int i = 0; i < 10; i++) nx[i] = m[i];
    s++;
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h++;
        if (h == 24) begin
          h = 0;
          nx[6] = (m[6] >= 7) ? 1 : m[6] + 1;
          d++;
          if (d > dim(mo, y)) begin
            d = 1; mo++;
            if (mo > 12) begin mo = 1; y = (y + 1) % 100; end
          end
        end
      end
    end
    nx[0] = enc(s, bin); nx[2] = enc(mi, bin);
    nx[7] = enc(d, bin); nx[8] = enc(mo, bin); nx[9] = enc(y, bin);
    if (h24) nx[4] = enc(h, bin);
    else begin
      h12 = (h % 12 == 0) ? 12 : h % 12;
      nx[4] = enc(h12, bin) | ((h >= 12) ? 128 : 0);
    end
  endfunction

  function automatic bit match_alarm();
    bit ok = 1;
    for (int k = 0; k < 3; k++)
      if (!(((m[2*k+1] & 8'hC0) == 8'hC0) || (m[2*k+1] == nx[2*k]))) ok = 0;
    return ok;
  endfunction

  function automatic bit m_irq();
    return (m_uf && m[11][4]) || (m_af && m[11][5]);
  endfunction

  function automatic int view(int i);
    if (i == 10) return (int'(m_busy) << 7) | m[10];
    if (i == 12) return (int'(m_irq()) << 7) | (int'(m_af) << 5) | (int'(m_uf) << 4);
    if (i == 13) return 8'h80;
    return m[i];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) m[i] = 0;
      m[6] = 1; m[7] = 1; m[8] = 1; m[11] = 8'h02;
      m_idx = 0; m_cnt = 0; m_rd = 0; m_busy = 0; m_uf = 0; m_af = 0;
    end else begin
      bit cm, al;
      cm = m_busy && m_cnt == 0 && !m[11][7];
      al = 0;
      if (ds && !we) m_rd = view(m_idx);
      if (cm) begin
        compute_next();
        al = match_alarm();
        for (int i = 0; i < 10; i++) m[i] = nx[i];
      end
      if (ds && !we && m_idx == 12) begin m_uf = 0; m_af = 0; end
      if (cm) m_uf = 1;
      if (al) m_af = 1;
      if (m_busy) begin
        if (m_cnt == 0) m_busy = 0; else m_cnt--;
      end else if (tick && !m[11][7]) begin
        m_busy = 1; m_cnt = UIP - 1;
      end
      if (ds && we) begin
        if (m_idx == 10) m[10] = ad & 8'h7F;
        else if (m_idx != 12 && m_idx != 13) m[m_idx] = ad;
      end
      if (as_s) m_idx = ad & 63;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_upd, e_alm;
      e_upd = m_busy && m_cnt == 0 && !m[11][7];
      e_alm = 0;
      if (e_upd) begin compute_next(); e_alm = match_alarm(); end
      chk("R3 uip_o", int'(uip), int'(m_busy));
      chk("R9 upd_o", int'(upd), int'(e_upd));
      chk("R8 alm_o", int'(alm), int'(e_alm));
      chk("R9 irq_o", int'(irq), int'(m_irq()));
      chk("R1 rd_o", int'(rd_o), m_rd);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic set_idx(input int i);
    @(negedge clk); #1 as_s = 1; ad = 8'(i);
    @(negedge clk); #1 as_s = 0;
  endtask
  task automatic wr_byte(input int i, input int v);
    set_idx(i);
    ds = 1; we = 1; ad = 8'(v);
    @(negedge clk); #1 ds = 0; we = 0;
  endtask
  task automatic rd_byte(input int i, output int v);
    set_idx(i);
    ds = 1; we = 0;
    @(negedge clk); #1 ds = 0;
    v = int'(rd_o);
  endtask
  task automatic tick_only();
    @(negedge clk); #1 tick = 1;
    @(negedge clk); #1 tick = 0;
  endtask
  task automatic tick_full();
    tick_only();
    repeat (UIP + 2) @(negedge clk);
  endtask
  task automatic set_time(input int s, input int mi, input int h);
    wr_byte(0, s); wr_byte(2, mi); wr_byte(4, h);
  endtask
  task automatic expect_byte(input string req, input int i, input int exp);
    int v;
    rd_byte(i, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;

    // reset state
    expect_byte("R10 valid byte after reset", 13, 8'h80);
    expect_byte("R2 ctl B reset", 11, 8'h02);
    expect_byte("R3 seconds reset", 0, 8'h00);
    expect_byte("R6 day of week reset", 6, 8'h01);

    // R2 plain storage and alarm/control readback
    wr_byte(14, 8'hA5); wr_byte(63, 8'h3C); wr_byte(1, 8'h77); wr_byte(10, 8'hFF);
    expect_byte("R2 byte 14", 14, 8'hA5);
    expect_byte("R2 byte 63", 63, 8'h3C);
    expect_byte("R2 alarm seconds", 1, 8'h77);
    expect_byte("R2 ctl A low bits", 10, 8'h7F);
    expect_byte("R1 repeat read 63", 63, 8'h3C);

    // R4/R6 BCD full rollover at end of century
    wr_byte(11, 8'h02);
    set_time(8'h59, 8'h59, 8'h23);
    wr_byte(6, 7); wr_byte(7, 8'h31); wr_byte(8, 8'h12); wr_byte(9, 8'h99);
    tick_only();
    expect_byte("R3 UIP bit during window", 10, 8'hFF);
    repeat (UIP) @(negedge clk);
    expect_byte("R4 BCD seconds wrap", 0, 8'h00);
    expect_byte("R3 minutes carry", 2, 8'h00);
    expect_byte("R3 hours carry", 4, 8'h00);
    expect_byte("R6 day of week wraps to 1", 6, 8'h01);
    expect_byte("R6 day of month wraps", 7, 8'h01);
    expect_byte("R6 month wraps", 8, 8'h01);
    expect_byte("R6 year wraps", 9, 8'h00);
    wr_byte(0, 8'h09); tick_full();
    expect_byte("R4 BCD 09 to 10", 0, 8'h10);

    // R4/R6 binary, leap handling
    wr_byte(11, 8'h06);
    wr_byte(0, 9); tick_full();
    expect_byte("R4 binary 9 to 10", 0, 8'h0A);
    set_time(59, 59, 23); wr_byte(7, 28); wr_byte(8, 2); wr_byte(9, 4);
    tick_full();
    expect_byte("R6 leap Feb 29", 7, 29);
    set_time(59, 59, 23); tick_full();
    expect_byte("R6 leap Mar 1 day", 7, 1);
    expect_byte("R6 leap Mar 1 month", 8, 3);
    set_time(59, 59, 23); wr_byte(7, 28); wr_byte(8, 2); wr_byte(9, 5);
    tick_full();
    expect_byte("R6 non-leap Mar 1", 8, 3);
    set_time(59, 59, 23); wr_byte(7, 30); wr_byte(8, 4);
    tick_full();
    expect_byte("R6 April has 30 days", 8, 5);

    // R5 12-hour mode, BCD
    wr_byte(11, 8'h00);
    set_time(8'h59, 8'h59, 8'h11); tick_full();
    expect_byte("R5 11 AM to 12 PM", 4, 8'h92);
    wr_byte(7, 8'h05); wr_byte(8, 8'h03);
    set_time(8'h59, 8'h59, 8'h91); tick_full();
    expect_byte("R5 11 PM to 12 AM", 4, 8'h12);
    expect_byte("R5 new day after midnight", 7, 8'h06);

    // R7 freeze
    wr_byte(11, 8'h82); wr_byte(0, 8'h10);
    tick_full();
    chk("R7 no window while frozen", int'(uip), 0);
    expect_byte("R7 seconds frozen", 0, 8'h10);

    // R8/R9 alarm and flags
    wr_byte(11, 8'h26);
    rd_byte(12, v);
    set_time(9, 5, 1);
    wr_byte(1, 10); wr_byte(3, 8'hC0); wr_byte(5, 1);
    tick_full();
    chk("R8 irq from alarm", int'(irq), 1);
    expect_byte("R8 flag byte alarm+update", 12, 8'hB0);
    expect_byte("R9 flags cleared by read", 12, 8'h00);
    chk("R9 irq clears", int'(irq), 0);
    wr_byte(1, 20); tick_full();
    expect_byte("R8 alarm mismatch", 12, 8'h10);
    wr_byte(11, 8'h16); tick_full();
    chk("R9 irq from update", int'(irq), 1);
    expect_byte("R9 flag byte update", 12, 8'h90);

    // R10 writes to flag and valid bytes ignored
    wr_byte(12, 8'hFF);
    expect_byte("R10 flag write ignored", 12, 8'h00);
    wr_byte(13, 8'h00);
    expect_byte("R10 valid write ignored", 13, 8'h80);

    // R11 write in commit cycle
    wr_byte(11, 8'h02);
    set_time(8'h59, 8'h10, 8'h05);
    set_idx(0);
    tick_only();
    do @(negedge clk); while (!upd);
    #1 ds = 1; we = 1; ad = 8'h30;
    @(negedge clk); #1 ds = 0; we = 0;
    expect_byte("R11 written seconds win", 0, 8'h30);
    expect_byte("R11 minutes still advance", 2, 8'h11);

    // R12 tick inside window ignored
    wr_byte(0, 8'h05);
    tick_only();
    @(negedge clk); #1 tick = 1;
    @(negedge clk); #1 tick = 0;
    repeat (UIP + 2) @(negedge clk);
    expect_byte("R12 single advance", 0, 8'h06);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule